// File: doc/BRIEF.md
# Parallel Flash Query Response Replicator

This block forms the read word that a bank of identical flash parts, wired side by side, returns while the bank sits in identification mode or in parameter-query mode. The host presents a byte address on the bus; the block rescales it to the index a single part would see, looks that index up either in a fixed per-part parameter table (82 bytes, given as a parameter) or in a two-entry identification map, and then copies the single-part answer into every device lane of the bank.

Three widths, all in bytes, configure it: the bank width, the width each part is actually driven at, and the widest mode each part supports. An access may be wider than the bank; the word is then assembled from several bank-width lookups at successive bank addresses. The answer is registered, so a read requested in one cycle is presented in the next, like the array read path beside it.

Top module: `flash_query_replicator`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A read accepted with `rd_en` high shows its word on `rd_data` with `rd_valid` high exactly one cycle later; in a cycle after `rd_en` was low, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R3: The per-part index is the byte address shifted right by log2(bank width) + log2(maximum part width) - log2(part width in use).
- R4: In query mode (`rd_mode` = 1) an index of 82 (0x52) or above yields a zero answer for that bank slice; index 81 still reads the last table byte.
- R5: When a part wider than one byte is driven one byte wide, the query byte is repeated across the part's full width instead of being padded with zeros, so every byte of the bank slice carries the table byte.
- R6: Any other mismatch between part width in use and maximum part width, or byte-wide use on a bank wider than four bytes, gives a zero query answer.
- R7: The single-part answer, one part-width lane wide, is copied into every part-width lane of the bank slice; with equal widths a query byte sits zero-extended in the low byte of each lane.
- R8: In identification mode (`rd_mode` = 0) only the low 8 bits of the index count: 0 gives the manufacturer code, 1 gives the part code, every other value gives zero; each lane carries the low part-width bytes of the code.
- R9: Size code `rd_size` selects 1, 2 or 4 bytes for codes 0, 1, 2 (larger codes clamp to the full word); when the access is wider than the bank, slice k is looked up at byte address `rd_addr` + k x bank width and placed at bytes k x bank width upward.
- R10: Bytes of `rd_data` above the access width are zero; an access narrower than the bank returns the low bytes of the first slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request this cycle |
| rd_mode | input | 1 | 0 = identification, 1 = parameter query |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_size | input | SIZE_W | log2 of access width in bytes |
| rd_valid | output | 1 | Read word valid this cycle |
| rd_data | output | 8*WORD_BYTES | Assembled read word |

## Verification
Every answer is due one clock after the cycle in which `rd_en` was sampled high, since the only register on the path is the output stage; `rd_valid` and the hold behaviour follow the same single-cycle rule. The bench drives a request on a falling edge and compares at the next falling edge, after exactly one rising edge, so each comparison sees the word of the request just made. Three instances with different width settings share the stimulus, covering byte-mode repetition, equal-width zero extension and the unsupported-width zero answer, with expected words rebuilt from the requirements by bench functions.

// File: rtl/fqr_pkg.sv
package fqr_pkg;

    localparam int TBL_LEN = 82;

    typedef enum logic {
        MODE_IDENT = 1'b0,
        MODE_QUERY = 1'b1
    } fqr_mode_e;

    typedef logic [TBL_LEN*8-1:0] fqr_table_t;

    function automatic fqr_table_t default_table();
        fqr_table_t t;
        t = '0;
        t[8*16 +: 8] = 8'h51;
        t[8*17 +: 8] = 8'h52;
        t[8*18 +: 8] = 8'h59;
        t[8*19 +: 8] = 8'h01;
        t[8*21 +: 8] = 8'h31;
        t[8*27 +: 8] = 8'h45;
        t[8*28 +: 8] = 8'h55;
        t[8*39 +: 8] = 8'h16;
        t[8*40 +: 8] = 8'h02;
        t[8*42 +: 8] = 8'h0B;
        t[8*44 +: 8] = 8'h01;
        t[8*49 +: 8] = 8'h50;
        t[8*50 +: 8] = 8'h52;
        t[8*51 +: 8] = 8'h49;
        return t;
    endfunction

    function automatic int clamp_lg(input int code, input int lg_max);
        return (code > lg_max) ? lg_max : code;
    endfunction

endpackage

// File: rtl/fqr_dev_resp.sv
module fqr_dev_resp
    import fqr_pkg::*;
#(
    parameter int         IDX_W     = 12,
    parameter int         BANK      = 2,
    parameter int         DEV       = 1,
    parameter int         MAXW      = 2,
    parameter fqr_table_t TABLE     = default_table(),
    parameter logic [15:0] MFR_CODE = 16'h5A3C,
    parameter logic [15:0] PART_CODE = 16'h17E4
) (
    input  logic [IDX_W-1:0] idx,
    input  fqr_mode_e        mode,
    output logic [8*DEV-1:0] lane
);
    localparam int  LW     = 8 * DEV;
    localparam bit  REPEAT = (DEV != MAXW);
    localparam bit  UNSUP  = REPEAT && ((DEV != 1) || (BANK > 4));
    localparam logic [LW+15:0] MFR_EXT  = {{LW{1'b0}}, MFR_CODE};
    localparam logic [LW+15:0] PART_EXT = {{LW{1'b0}}, PART_CODE};

    logic [7:0]        tbyte;
    logic [8*MAXW-1:0] qwide;
    logic [LW-1:0]     qlane;
    logic [LW-1:0]     idlane;

    // table lookup; out-of-range index leaves zero
    always_comb begin
        tbyte = 8'h00;
        for (int e = 0; e < TBL_LEN; e++) begin
            if (idx == IDX_W'(e)) tbyte = TABLE[8*e +: 8];
        end
    end

    // one part's answer across its maximum width
    for (genvar m = 0; m < MAXW; m++) begin : g_wide
        if (m == 0 || REPEAT) begin : g_fill
            assign qwide[8*m +: 8] = tbyte;
        end else begin : g_pad
            assign qwide[8*m +: 8] = 8'h00;
        end
    end

    if (UNSUP) begin : g_unsup
        assign qlane = '0;
    end else begin : g_sup
        assign qlane = qwide[LW-1:0];
    end

    always_comb begin
        unique case (idx[7:0])
            8'd0:    idlane = MFR_EXT[LW-1:0];
            8'd1:    idlane = PART_EXT[LW-1:0];
            default: idlane = '0;
        endcase
    end

    assign lane = (mode == MODE_QUERY) ? qlane : idlane;

endmodule

// File: rtl/fqr_lane_rep.sv
module fqr_lane_rep #(
    parameter int BANK = 2,
    parameter int DEV  = 1
) (
    input  logic [8*DEV-1:0]  lane,
    output logic [8*BANK-1:0] slice
);
    localparam int NLANE = BANK / DEV;

    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        assign slice[8*DEV*j +: 8*DEV] = lane;
    end
    if (NLANE * DEV < BANK) begin : g_rem
        assign slice[8*BANK-1 : 8*DEV*NLANE] = '0;
    end

endmodule

// File: rtl/fqr_pack.sv
module fqr_pack
    import fqr_pkg::*;
#(
    parameter int RAW_BYTES  = 4,
    parameter int WORD_BYTES = 4,
    parameter int SIZE_W     = 2
) (
    input  logic [8*RAW_BYTES-1:0]  raw,
    input  logic [SIZE_W-1:0]       size,
    output logic [8*WORD_BYTES-1:0] word
);
    localparam int LG_WORD = $clog2(WORD_BYTES);

    int nbytes;
    always_comb nbytes = 1 << clamp_lg(int'(size), LG_WORD);

    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_byte
        if (j < RAW_BYTES) begin : g_src
            assign word[8*j +: 8] = (j < nbytes) ? raw[8*j +: 8] : 8'h00;
        end else begin : g_none
            assign word[8*j +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/flash_query_replicator.sv
module flash_query_replicator
    import fqr_pkg::*;
#(
    parameter int          ADDR_W        = 11,
    parameter int          BANK_BYTES    = 2,
    parameter int          DEV_BYTES     = 1,
    parameter int          MAX_DEV_BYTES = 2,
    parameter int          WORD_BYTES    = 4,
    parameter int          SIZE_W        = 2,
    parameter fqr_table_t  TABLE         = default_table(),
    parameter logic [15:0] MFR_CODE      = 16'h5A3C,
    parameter logic [15:0] PART_CODE     = 16'h17E4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic                    rd_mode,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [SIZE_W-1:0]       rd_size,
    output logic                    rd_valid,
    output logic [8*WORD_BYTES-1:0] rd_data
);
    localparam int SHIFT = $clog2(BANK_BYTES) + $clog2(MAX_DEV_BYTES) - $clog2(DEV_BYTES);
    localparam int NCH   = (WORD_BYTES >= BANK_BYTES) ? (WORD_BYTES / BANK_BYTES) : 1;
    localparam int RAW   = NCH * BANK_BYTES;
    localparam int CW    = ADDR_W + $clog2(RAW) + 1;

    fqr_mode_e             mode;
    logic [8*RAW-1:0]      raw;
    logic [8*WORD_BYTES-1:0] word;

    assign mode = fqr_mode_e'(rd_mode);

    // one bank-width lookup per slice of the access
    for (genvar k = 0; k < NCH; k++) begin : g_slice
        logic [CW-1:0]           a_k;
        logic [CW-1:0]           idx_k;
        logic [8*DEV_BYTES-1:0]  lane_k;

        assign a_k   = CW'(rd_addr) + CW'(k * BANK_BYTES);
        assign idx_k = a_k >> SHIFT;

        fqr_dev_resp #(
            .IDX_W    (CW),
            .BANK     (BANK_BYTES),
            .DEV      (DEV_BYTES),
            .MAXW     (MAX_DEV_BYTES),
            .TABLE    (TABLE),
            .MFR_CODE (MFR_CODE),
            .PART_CODE(PART_CODE)
        ) u_resp (
            .idx (idx_k),
            .mode(mode),
            .lane(lane_k)
        );

        fqr_lane_rep #(
            .BANK(BANK_BYTES),
            .DEV (DEV_BYTES)
        ) u_rep (
            .lane (lane_k),
            .slice(raw[8*BANK_BYTES*k +: 8*BANK_BYTES])
        );
    end

    fqr_pack #(
        .RAW_BYTES (RAW),
        .WORD_BYTES(WORD_BYTES),
        .SIZE_W    (SIZE_W)
    ) u_pack (
        .raw (raw),
        .size(rd_size),
        .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= word;
        end
    end

endmodule

// File: rtl/flash_query_replicator_chk.sv
module flash_query_replicator_chk #(
    parameter int WORD_BYTES = 4,
    parameter int BANK_BYTES = 2,
    parameter int DEV_BYTES  = 1,
    parameter int SIZE_W     = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    rd_en,
    input logic [SIZE_W-1:0]       rd_size,
    input logic                    rd_valid,
    input logic [8*WORD_BYTES-1:0] rd_data
);
    localparam int LG_WORD = $clog2(WORD_BYTES);
    localparam int LG_BANK = $clog2(BANK_BYTES);
    localparam int NLANE   = BANK_BYTES / DEV_BYTES;

    // R1: reset clears the output stage
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0));

    // R2: one-cycle latency of the valid flag
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R10: bytes above a one-byte access stay zero
    if (WORD_BYTES > 1) begin : g_one
        a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_size == '0) |=> (rd_data[8*WORD_BYTES-1:8] == '0));
    end

    // R7: every part lane of the first slice matches lane zero
    if (NLANE > 1 && BANK_BYTES <= WORD_BYTES) begin : g_lanes
        for (genvar j = 1; j < NLANE; j++) begin : g_l
            a_r7_lane_copy: assert property (@(posedge clk) disable iff (rst)
                (rd_en && (int'(rd_size) >= LG_BANK) && (LG_WORD >= LG_BANK)) |=>
                (rd_data[8*DEV_BYTES*j +: 8*DEV_BYTES] == rd_data[8*DEV_BYTES-1:0]));
        end
    end

endmodule

bind flash_query_replicator flash_query_replicator_chk #(
    .WORD_BYTES(WORD_BYTES),
    .BANK_BYTES(BANK_BYTES),
    .DEV_BYTES (DEV_BYTES),
    .SIZE_W    (SIZE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_size (rd_size),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
);

// File: tb/flash_query_replicator_test.sv
`timescale 1ns/1ps
module flash_query_replicator_test;

    localparam int          ADDR_W = 11;
    localparam logic [15:0] MFR    = 16'h5A3C;
    localparam logic [15:0] PART   = 16'h17E4;

    function automatic logic [7:0] tb_byte(input int i);
        case (i)
            0:  return 8'h00;
            16: return 8'h51;
            17: return 8'h52;
            18: return 8'h59;
            19: return 8'h01;
            33: return 8'h3C;
            44: return 8'h01;
            64: return 8'hC7;
            81: return 8'hA5;
            default: return 8'(i * 3 + 1);
        endcase
    endfunction

    function automatic fqr_pkg::fqr_table_t tb_table();
        fqr_pkg::fqr_table_t t;
        for (int i = 0; i < 82; i++) t[8*i +: 8] = tb_byte(i);
        return t;
    endfunction

    localparam fqr_pkg::fqr_table_t TBL = tb_table();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        rd_mode = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]  rd_size = 2'd0;
    logic        v_a, v_b, v_c;
    logic [31:0] d_a, d_b, d_c;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    flash_query_replicator #(.ADDR_W(ADDR_W), .BANK_BYTES(2), .DEV_BYTES(1),
        .MAX_DEV_BYTES(2), .TABLE(TBL), .MFR_CODE(MFR), .PART_CODE(PART)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_valid(v_a), .rd_data(d_a));

    flash_query_replicator #(.ADDR_W(ADDR_W), .BANK_BYTES(4), .DEV_BYTES(2),
        .MAX_DEV_BYTES(2), .TABLE(TBL), .MFR_CODE(MFR), .PART_CODE(PART)) uut_eq (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_valid(v_b), .rd_data(d_b));

    flash_query_replicator #(.ADDR_W(ADDR_W), .BANK_BYTES(4), .DEV_BYTES(2),
        .MAX_DEV_BYTES(4), .TABLE(TBL), .MFR_CODE(MFR), .PART_CODE(PART)) uut_bad (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_valid(v_c), .rd_data(d_c));

    function automatic int lg(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // expected word from the requirements
    function automatic logic [31:0] model(input int bank, input int dev, input int mx,
                                          input bit q, input int addr, input int size);
        logic [31:0] res = '0;
        int nch = (4 >= bank) ? 4 / bank : 1;
        int sh  = lg(bank) + lg(mx) - lg(dev);
        bit bad = (dev != mx) && (dev != 1 || bank > 4);
        int nb  = 1 << ((size > 2) ? 2 : size);
        for (int k = 0; k < nch; k++) begin
            int idx = (addr + k * bank) >> sh;
            logic [31:0] lv;
            logic [63:0] sl = '0;
            if (q) lv = (bad || idx >= 82) ? 32'h0 : {24'h0, tb_byte(idx)};
            else   lv = ((idx & 255) == 0) ? {16'h0, MFR} :
                        ((idx & 255) == 1) ? {16'h0, PART} : 32'h0;
            lv = lv & ((dev >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * dev)) - 1));
            for (int j = 0; j < bank / dev; j++) sl = sl | (64'(lv) << (8 * dev * j));
            res = res | 32'(sl << (8 * bank * k));
        end
        for (int j = 0; j < 4; j++) if (j >= nb) res[8*j +: 8] = 8'h00;
        return res;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input string tag, input bit q, input int addr, input int size);
        @(negedge clk);
        rd_en = 1'b1; rd_mode = q; rd_addr = ADDR_W'(addr); rd_size = 2'(size);
        @(negedge clk);
        chk({tag, " R2 valid"}, {31'h0, v_a & v_b & v_c}, 32'h1);
        chk({tag, " x8-on-x16"}, d_a, model(2, 1, 2, q, addr, size));
        chk({tag, " equal-width"}, d_b, model(4, 2, 2, q, addr, size));
        chk({tag, " unsupported"}, d_c, model(4, 2, 4, q, addr, size));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] keep_a;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 valid", {31'h0, v_a}, 32'h0);
        chk("R1 data", d_a, 32'h0);

        rd("R3 R5 query QRY", 1'b1, 16 * 4, 2);          // index 0x10 on x8-on-x16
        chk("R5 all bytes equal", d_a, 32'h5151_5151);
        rd("R7 equal-width pad", 1'b1, 16 * 4, 2);
        chk("R7 zero-extended lanes", d_b, 32'h0051_0051);
        rd("R4 last index", 1'b1, 81 * 4, 2);
        chk("R4 index 81", d_a, 32'hA5A5_A5A5);
        rd("R4 past end", 1'b1, 82 * 4, 2);
        chk("R4 index 82 zero", d_a, 32'h0);
        rd("R6 unsupported zero", 1'b1, 64 * 4, 2);
        chk("R6 query zero", d_c, 32'h0);
        rd("R8 ident manuf", 1'b0, 0, 2);
        chk("R8 manuf lanes", d_b, 32'h5A3C_5A3C);
        rd("R8 ident part", 1'b0, 4, 2);
        rd("R8 ident other", 1'b0, 8, 2);
        rd("R8 low 8 bits wrap", 1'b0, 1024 + 4, 2);
        chk("R8 part after wrap", d_a, 32'hE4E4_E4E4);
        rd("R9 slice straddle", 1'b1, 17 * 4 + 2, 2);
        rd("R9 clamp size 3", 1'b1, 18 * 4, 3);
        rd("R10 one byte", 1'b1, 17 * 4, 0);
        chk("R10 upper zero", d_b, 32'h0000_0052);
        rd("R10 two bytes", 1'b0, 0, 1);

        // R2 hold: no request, output must keep the last word
        keep_a = d_a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = ADDR_W'(16 * 4); rd_mode = 1'b1;
        @(negedge clk);
        chk("R2 idle valid low", {31'h0, v_a}, 32'h0);
        chk("R2 idle hold", d_a, keep_a);

        // R3 R9 random mix
        for (int n = 0; n < 400; n++) begin
            rd("R3 R9 random", 1'($urandom % 2), int'($urandom % 2048), int'($urandom % 4));
        end

        @(negedge clk);
        rd_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule